// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-stage register that, on each rising clock edge, either keeps its contents, moves them one place toward the high stage, moves them one place toward the low stage, or captures a whole word. A two-bit mode input selects the operation. An active-low asynchronous clear empties every stage at once.

The word is captured from, and presented on, a single set of bidirectional pins. The register drives those pins only when both active-low enables are low. It stops driving them during a capture cycle so that external data can be sampled without contention. Stage 0 and the top stage each also appear on a dedicated output that is always driven. Joining one block's top-stage output to the next block's low-side serial input builds longer chains.

Inside the block, each shared pin is handled as a separate input, output and drive enable. A thin top level joins these into real tri-state pins.

Top module: `usr_shift_reg_io`

## Requirements
- R1: With mode_i = 2'b00, a rising clock edge leaves every stage unchanged.
- R2: While rst_ni is low, every stage reads 0 immediately, without waiting for a clock edge and whatever mode_i is. first_o and last_o are then 0.
- R3: With mode_i = 2'b01, a rising edge loads ser_r_i into stage 0 and stage n-1 into stage n, for every n from 1 to the top stage.
- R4: With mode_i = 2'b10, a rising edge loads ser_l_i into the top stage and stage n+1 into stage n, for every n from 0 to one below the top stage.
- R5: With mode_i = 2'b11, a rising edge loads bit n of data_io into stage n.
- R6: data_io[n] carries stage n only when oe1_ni and oe2_ni are both low and mode_i is not 2'b11. Otherwise every data_io pin is high-impedance.
- R7: first_o always shows stage 0 and last_o always shows the top stage, whatever the enables and the mode are.
- R8: When two blocks share a mode, and the first block's last_o feeds the second block's ser_r_i, sixteen shifts of mode 2'b01 move a 16-bit serial word into the pair. The first bit sent ends up in the second block's top stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every operation acts on the rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift toward top, 10 shift toward stage 0, 11 capture |
| ser_r_i | input | 1 | Serial bit entering stage 0 when shifting toward the top |
| ser_l_i | input | 1 | Serial bit entering the top stage when shifting toward stage 0 |
| oe1_ni | input | 1 | Bus drive enable, active low |
| oe2_ni | input | 1 | Bus drive enable, active low |
| data_io | inout | 8 | Capture inputs and tri-state register outputs |
| first_o | output | 1 | Stage 0, always driven |
| last_o | output | 1 | Top stage, always driven |

## Verification
The clear and a shift can fall in the same cycle. The bench lowers rst_ni between clock edges in the middle of a random shift run on a two-block chain. It expects zeros on the end outputs and the bus within a nanosecond, and expects the next edge to be ignored. Bus ownership and capture also coincide, because capture mode must release the pins in the same cycle that it samples them. The bench drives the pins during every capture cycle and checks that the captured word appears once the register drives the pins again. A 16-bit reference model of the chain judges each cycle.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int unsigned Width = 8
) (
  input  logic [1:0]       mode_i,
  input  logic [Width-1:0] q_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [Width-1:0] pin_i,
  output logic [Width-1:0] d_o
);
  localparam int unsigned Top = Width - 1;

  for (genvar i = 0; i < Width; i++) begin : g_bit
    logic from_low, from_high;
    if (i == 0) begin : g_lo_end
      assign from_low = ser_r_i;
    end else begin : g_lo_mid
      assign from_low = q_i[i-1];
    end
    if (i == Top) begin : g_hi_end
      assign from_high = ser_l_i;
    end else begin : g_hi_mid
      assign from_high = q_i[i+1];
    end

    always_comb begin
      unique case (usr_mode_e'(mode_i))
        MODE_UP:   d_o[i] = from_low;
        MODE_DOWN: d_o[i] = from_high;
        MODE_LOAD: d_o[i] = pin_i[i];
        default:   d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_drv.sv
module usr_drv
  import usr_pkg::*;
#(
  parameter int unsigned Width = 8
) (
  input  logic [1:0]       mode_i,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  input  logic [Width-1:0] q_i,
  output logic [Width-1:0] pin_o,
  output logic [Width-1:0] pin_oe_o
);
  logic drive;

  // capture mode releases the bus so outside data is sampled cleanly
  assign drive    = !oe1_ni && !oe2_ni && (usr_mode_e'(mode_i) != MODE_LOAD);
  assign pin_o    = q_i;
  assign pin_oe_o = {Width{drive}};
endmodule

// File: rtl/usr_core.sv
module usr_core
  import usr_pkg::*;
#(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  input  logic [Width-1:0] pin_i,
  output logic [Width-1:0] pin_o,
  output logic [Width-1:0] pin_oe_o,
  output logic             first_o,
  output logic             last_o
);
  localparam int unsigned Top = Width - 1;

  logic [Width-1:0] q_q, d;

  usr_next #(.Width(Width)) u_next (
    .mode_i (mode_i),
    .q_i    (q_q),
    .ser_r_i(ser_r_i),
    .ser_l_i(ser_l_i),
    .pin_i  (pin_i),
    .d_o    (d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d;
  end

  usr_drv #(.Width(Width)) u_drv (
    .mode_i  (mode_i),
    .oe1_ni  (oe1_ni),
    .oe2_ni  (oe2_ni),
    .q_i     (q_q),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o)
  );

  assign first_o = q_q[0];
  assign last_o  = q_q[Top];

  a_r1_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HOLD) |=> (q_q == $past(q_q)));
  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ($past(q_q) == '0));
  a_r3_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP) |=> (q_q == {$past(q_q[Top-1:0]), $past(ser_r_i)}));
  a_r4_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN) |=> (q_q == {$past(ser_l_i), $past(q_q[Top:1])}));
  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD) |=> (q_q == $past(pin_i)));
  a_r6_release_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOAD || oe1_ni || oe2_ni) |-> (pin_oe_o == '0));
  a_r7_ends_match_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o[0] && pin_oe_o[Top]) |-> (first_o == pin_o[0] && last_o == pin_o[Top]));
endmodule

// File: rtl/usr_shift_reg_io.sv
module usr_shift_reg_io #(
  parameter int unsigned Width = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  inout  wire  [Width-1:0] data_io,
  output logic             first_o,
  output logic             last_o
);
  logic [Width-1:0] pin_in, pin_out, pin_oe;

  usr_core #(.Width(Width)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .ser_r_i (ser_r_i),
    .ser_l_i (ser_l_i),
    .oe1_ni  (oe1_ni),
    .oe2_ni  (oe2_ni),
    .pin_i   (pin_in),
    .pin_o   (pin_out),
    .pin_oe_o(pin_oe),
    .first_o (first_o),
    .last_o  (last_o)
  );

  for (genvar i = 0; i < Width; i++) begin : g_pad
    assign data_io[i] = pin_oe[i] ? pin_out[i] : 1'bz;
    assign pin_in[i]  = data_io[i];
  end
endmodule

// File: tb/tb_usr_shift_reg_io.sv
module tb_usr_shift_reg_io;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sr = 1'b0, sl = 1'b0;
  logic        oe1_n = 1'b0, oe2_n = 1'b0;
  logic        drv = 1'b0;
  logic [15:0] drv_val = '0;
  logic [15:0] chain = '0;
  logic [1:0]  prev_mode = 2'b00;
  logic        prev_rst = 1'b1;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  wire [7:0] bus0, bus1;
  wire       f0, l0, f1, l1;

  assign bus0 = drv ? drv_val[7:0]  : 8'bz;
  assign bus1 = drv ? drv_val[15:8] : 8'bz;

  usr_shift_reg_io dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_r_i(sr), .ser_l_i(f1),
    .oe1_ni(oe1_n), .oe2_ni(oe2_n), .data_io(bus0), .first_o(f0), .last_o(l0)
  );
  usr_shift_reg_io u_hi (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_r_i(l0), .ser_l_i(sl),
    .oe1_ni(oe1_n), .oe2_ni(oe2_n), .data_io(bus1), .first_o(f1), .last_o(l1)
  );

  function automatic logic [15:0] chain_next(logic [15:0] c, logic [1:0] m,
                                             logic r, logic l, logic [15:0] ld);
    case (m)
      2'b01:   return {c[14:0], r};
      2'b10:   return {l, c[15:1]};
      2'b11:   return ld;
      default: return c;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m, logic r);
    if (!r) return "R2";
    case (m)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic cmp_outputs();
    check(f0 == chain[0], "R7 first_o", {15'd0, f0}, {15'd0, chain[0]});
    check(l1 == chain[15], "R7 last_o", {15'd0, l1}, {15'd0, chain[15]});
    if (!oe1_n && !oe2_n && mode != 2'b11 && !drv)
      check({bus1, bus0} == chain, mode_tag(prev_mode, prev_rst), {bus1, bus0}, chain);
    if (drv)
      check({bus1, bus0} == drv_val, "R6 bus released", {bus1, bus0}, drv_val);
  endtask

  task automatic do_cycle(logic [1:0] m, logic r, logic l, logic o1, logic o2,
                          logic d, logic [15:0] dv);
    @(negedge clk);
    cmp_outputs();
    prev_rst  = rst_n;
    rst_n     = 1'b1;
    mode = m; sr = r; sl = l; oe1_n = o1; oe2_n = o2; drv = d; drv_val = dv;
    prev_mode = m;
    @(posedge clk);
    if (rst_n) chain = chain_next(chain, m, r, l, dv);
  endtask

  task automatic rand_cycle(bit mid_reset);
    logic [1:0] m;
    logic o1, o2, d;
    m  = 2'($urandom_range(0, 3));
    o1 = ($urandom_range(0, 3) == 0);
    o2 = ($urandom_range(0, 3) == 0);
    d  = (m == 2'b11) || ((o1 || o2) && $urandom_range(0, 1) == 1);
    @(negedge clk);
    cmp_outputs();
    prev_rst = rst_n;
    rst_n    = 1'b1;
    mode = m; sr = 1'($urandom); sl = 1'($urandom);
    oe1_n = o1; oe2_n = o2; drv = d; drv_val = 16'($urandom);
    prev_mode = m;
    if (mid_reset) begin
      #2 rst_n = 1'b0;
      #1 chain = '0;
      prev_rst = 1'b0;
      check({l1, f0} == 2'b00, "R2 async clear ends", {14'd0, l1, f0}, 16'd0);
      if (!o1 && !o2 && m != 2'b11 && !d)
        check({bus1, bus0} == 16'd0, "R2 async clear bus", {bus1, bus0}, 16'd0);
    end
    @(posedge clk);
    if (rst_n) chain = chain_next(chain, m, sr, sl, drv_val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    void'($urandom(32'd2718));
    #3;
    check({bus1, bus0} == 16'd0, "R2 reset state bus", {bus1, bus0}, 16'd0);
    check({l1, f0} == 2'b00, "R2 reset state ends", {14'd0, l1, f0}, 16'd0);
    prev_rst = 1'b0;

    // capture, then hold with enables closed, then reopen
    do_cycle(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h96E1);
    do_cycle(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1234);
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
    do_cycle(2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    do_cycle(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);

    // R8: 16-bit serial word through the two-block chain, first bit sent ends at top
    pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--)
      do_cycle(2'b01, pat[i], 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    check({bus1, bus0} == pat, "R8 cascade serial word", {bus1, bus0}, pat);

    // left shift out through the chain with enables closed: ends must follow
    for (int i = 0; i < 6; i++)
      do_cycle(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h5A5A);

    for (int k = 0; k < 400; k++) rand_cycle(k == 137 || k == 301);
    @(negedge clk);
    cmp_outputs();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule